// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Idle Fill

The block turns parallel characters written by a processor into a serial bit stream on a single transmit line. A character first lands in a one-entry holding register. It is copied into a separate output shift register only once that register has sent its last bit, so the processor can queue the next character while the current one is still leaving. Bits advance on falling edges of an external transmit clock. That clock is sampled in the system clock domain and divided by 1, 16 or 64.

In asynchronous framing each character gets a low start bit and a high stop bit, and the line rests high between characters. In synchronous framing characters are sent back to back without framing bits, one bit per transmit-clock period. Whenever no data character is waiting at a character boundary, the block sends a programmed fill character instead. A clear-to-send input gates the start of every character. A break input forces the line low. Two status outputs report that the holding register is free and that all data has left the transmitter.

Top module: `sertx_top`

## Requirements
- R1: In asynchronous mode (sync_mode=0) a character is sent as one 0 start bit, then the 8 data bits with bit 0 first, then one 1 stop bit. Between characters txd rests at 1.
- R2: In asynchronous mode one bit lasts 1, 16 or 64 transmit-clock periods, for fac_sel values 2'b00, 2'b01 and 2'b10 (2'b11 also selects 64).
- R3: In synchronous mode (sync_mode=1) characters are sent as 8 bits with bit 0 first and no start or stop bit. Each bit lasts one transmit-clock period whatever fac_sel holds.
- R4: In synchronous mode, when the holding register is empty at a character boundary, the block sends sync_char in that slot.
- R5: txd changes only after a falling edge of tx_clk, within 4 clk cycles of that edge. It is therefore steady at the next rising edge.
- R6: buf_rdy is 1 exactly while the holding register is empty. A held character moves to the shift register only when the previous character has finished, and then follows it without a gap.
- R7: A write (wr_en=1) while buf_rdy is 0 is ignored. The held character is kept and the written value is never sent.
- R8: tx_empty is 1 when tx_en is 1, the holding register is empty and no data character is being shifted (fill characters do not count). After reset it stays 0 until tx_en is 1.
- R9: While brk is 1, txd is 0. When brk returns to 0, the line returns to its normal level.
- R10: While cts_n is 1 no new character begins: txd stays at 1 and a held character stays held.
- R11: While rst is 1 and right after it, txd is 1, buf_rdy is 1 and tx_empty is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| tx_clk | input | 1 | Transmit clock; bits advance on its falling edges |
| tx_en | input | 1 | Transmitter enable |
| sync_mode | input | 1 | 1 selects synchronous framing, 0 asynchronous |
| fac_sel | input | 2 | Clock factor: 00 = 1, 01 = 16, 1x = 64 (asynchronous only) |
| sync_char | input | DATA_W | Fill character for synchronous mode |
| brk | input | 1 | Forces txd low while 1 |
| cts_n | input | 1 | Clear-to-send, active low; gates character starts |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to queue |
| txd | output | 1 | Serial transmit line |
| buf_rdy | output | 1 | Holding register empty |
| tx_empty | output | 1 | No data character left in the transmitter |

## Verification
The bench builds the block with its defaults: 8 data bits and factors of 16 and 64. Each factor code is therefore exercised against the real bit lengths. The 64 case is limited to two characters, and both 1x codes are run. In synchronous runs fac_sel is left at the 16 code, so any factor leaking into synchronous mode would break the received stream. The fill character, 8'h16, has bit 0 clear, which lets the monitor lock onto character boundaries from the first falling bit after enable.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [1:0] {
        FAC_X1   = 2'b00,
        FAC_X16  = 2'b01,
        FAC_X64  = 2'b10,
        FAC_X64B = 2'b11
    } fac_e;

endpackage

// File: rtl/sertx_tick.sv
module sertx_tick
    import sertx_pkg::*;
#(
    parameter int FAC_MID = 16,
    parameter int FAC_HI  = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_clk,
    input  logic       sync_mode,
    input  logic [1:0] fac_sel,
    output logic       bit_tick
);
    localparam int CW = $clog2(FAC_HI);

    typedef struct packed {
        logic [2:0]    sy;
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t q, d;
    logic fall;
    logic [CW-1:0] lim;

    always_comb begin
        d        = q;
        bit_tick = 1'b0;
        d.sy     = {q.sy[1], q.sy[0], tx_clk};
        fall     = q.sy[2] & ~q.sy[1];
        if (sync_mode) begin
            lim = '0;
        end else begin
            case (fac_e'(fac_sel))
                FAC_X1:  lim = '0;
                FAC_X16: lim = CW'(FAC_MID - 1);
                default: lim = CW'(FAC_HI - 1);
            endcase
        end
        if (fall) begin
            if (q.cnt >= lim) begin
                d.cnt    = '0;
                bit_tick = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          pop,
    output logic          full,
    output logic [DW-1:0] data
);
    typedef struct packed {
        logic          full;
        logic [DW-1:0] data;
    } hold_st_t;

    hold_st_t q, d;

    always_comb begin
        d = q;
        if (pop) begin
            d.full = 1'b0;
        end else if (wr_en && !q.full) begin
            d.full = 1'b1;
            d.data = wr_data;
        end
        full = q.full;
        data = q.data;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // R7
    ignored_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (q.full && wr_en && !pop) |=> (q.full && $stable(q.data)));

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_tick,
    input  logic          go,
    input  logic          sync_mode,
    input  logic [DW-1:0] sync_char,
    input  logic          hold_full,
    input  logic [DW-1:0] hold_data,
    output logic          pop,
    output logic          line,
    output logic          data_busy
);
    localparam int FW = DW + 2;
    localparam int NW = $clog2(FW + 1);

    typedef struct packed {
        logic [FW-1:0] sr;
        logic [NW-1:0] left;
        logic          line;
        logic          is_data;
    } shift_st_t;

    shift_st_t q, d;
    logic [DW-1:0] pick;
    logic [FW-1:0] frame;

    always_comb begin
        d     = q;
        pop   = 1'b0;
        pick  = hold_full ? hold_data : sync_char;
        frame = sync_mode ? {2'b11, pick} : {1'b1, pick, 1'b0};
        if (bit_tick) begin
            if (q.left <= NW'(1)) begin
                if (go && (hold_full || sync_mode)) begin
                    d.line    = frame[0];
                    d.sr      = frame >> 1;
                    d.left    = sync_mode ? NW'(DW) : NW'(FW);
                    d.is_data = hold_full;
                    pop       = hold_full;
                end else begin
                    d.line    = 1'b1;
                    d.left    = '0;
                    d.is_data = 1'b0;
                end
            end else begin
                d.line = q.sr[0];
                d.sr   = q.sr >> 1;
                d.left = q.left - 1'b1;
            end
        end
        line      = q.line;
        data_busy = q.is_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            q.line <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // R5
    line_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(q.line));

    // R10
    cts_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!go && q.left == '0) |=> (q.left == '0 && q.line));

endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
    parameter int DATA_W  = 8,
    parameter int FAC_MID = 16,
    parameter int FAC_HI  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_clk,
    input  logic              tx_en,
    input  logic              sync_mode,
    input  logic [1:0]        fac_sel,
    input  logic [DATA_W-1:0] sync_char,
    input  logic              brk,
    input  logic              cts_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              buf_rdy,
    output logic              tx_empty
);
    logic              bit_tick;
    logic              go;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              pop;
    logic              line;
    logic              data_busy;

    assign go = tx_en & ~cts_n;

    sertx_tick #(.FAC_MID(FAC_MID), .FAC_HI(FAC_HI)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .tx_clk    (tx_clk),
        .sync_mode (sync_mode),
        .fac_sel   (fac_sel),
        .bit_tick  (bit_tick)
    );

    sertx_hold #(.DW(DATA_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pop     (pop),
        .full    (hold_full),
        .data    (hold_data)
    );

    sertx_shift #(.DW(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .bit_tick  (bit_tick),
        .go        (go),
        .sync_mode (sync_mode),
        .sync_char (sync_char),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .pop       (pop),
        .line      (line),
        .data_busy (data_busy)
    );

    assign txd      = brk ? 1'b0 : line;
    assign buf_rdy  = ~hold_full;
    assign tx_empty = tx_en & ~hold_full & ~data_busy;

    // R8
    empty_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> buf_rdy);

    // R6
    rdy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_rdy) |-> $past(pop));

endmodule

// File: tb/sim_sertx_top.sv
module sim_sertx_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_clk = 1'b1;
    logic       tx_en = 1'b0;
    logic       sync_mode = 1'b0;
    logic [1:0] fac_sel = 2'b01;
    logic [7:0] sync_char = 8'h16;
    logic       brk = 1'b0;
    logic       cts_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, buf_rdy, tx_empty;

    int n_chk = 0;
    int n_bad = 0;
    int k_fac = 16;
    int fills = 0;
    int lows;
    bit mon_async = 1'b0;
    bit mon_sync = 1'b0;
    string mtag = "R1 R2";
    logic [7:0] expq[$];

    sertx_top u0 (
        .clk(clk), .rst(rst), .tx_clk(tx_clk), .tx_en(tx_en),
        .sync_mode(sync_mode), .fac_sel(fac_sel), .sync_char(sync_char),
        .brk(brk), .cts_n(cts_n), .wr_en(wr_en), .wr_data(wr_data),
        .txd(txd), .buf_rdy(buf_rdy), .tx_empty(tx_empty)
    );

    initial forever #4 clk = ~clk;

    initial begin
        forever begin
            repeat (8) @(posedge clk);
            #1 tx_clk = ~tx_clk;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic score(input logic [7:0] got, input bit syncm, input string tag);
        if (syncm && got == sync_char && (expq.size() == 0 || expq[0] != got)) begin
            fills++;
        end else if (expq.size() == 0) begin
            check(1'b0, tag, "unexpected character", got, 0);
        end else begin
            check(got === expq[0], tag, "received character", got, expq[0]);
            void'(expq.pop_front());
        end
    endtask

    // Monitor: samples at rising tx_clk edges, mid-way between falling edges (R5)
    initial begin : monitor
        logic [7:0] got;
        forever begin
            @(posedge tx_clk);
            if (mon_async && txd === 1'b0) begin
                repeat ((k_fac > 1) ? (k_fac / 2 - 1) : 0) @(posedge tx_clk);
                check(txd === 1'b0, mtag, "start bit", txd, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (k_fac) @(posedge tx_clk);
                    got[i] = txd;
                end
                repeat (k_fac) @(posedge tx_clk);
                check(txd === 1'b1, mtag, "stop bit", txd, 1);
                score(got, 1'b0, mtag);
            end else if (mon_sync && txd === 1'b0) begin
                got[0] = 1'b0;
                for (int i = 1; i < 8; i++) begin
                    @(posedge tx_clk);
                    got[i] = txd;
                end
                score(got, 1'b1, "R3");
                while (mon_sync) begin
                    for (int i = 0; i < 8; i++) begin
                        @(posedge tx_clk);
                        got[i] = txd;
                    end
                    score(got, 1'b1, "R3");
                end
            end
        end
    end

    task automatic raw_write(input logic [7:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic send(input logic [7:0] v);
        @(negedge clk);
        while (!buf_rdy) @(negedge clk);
        expq.push_back(v);
        raw_write(v);
    endtask

    task automatic drain(input string tag);
        @(negedge clk);
        while (!tx_empty) @(negedge clk);
        repeat (k_fac * 16 + 50) @(negedge clk);
        check(expq.size() == 0, tag, "characters still expected", expq.size(), 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin : main
        repeat (10) @(negedge clk);
        // R11: state during reset
        check(txd === 1'b1 && buf_rdy === 1'b1 && tx_empty === 1'b0, "R11",
              "outputs in reset", {txd, buf_rdy, tx_empty}, 3'b110);
        rst = 1'b0;
        @(negedge clk);
        check(txd === 1'b1 && buf_rdy === 1'b1 && tx_empty === 1'b0, "R11",
              "outputs after reset", {txd, buf_rdy, tx_empty}, 3'b110);
        repeat (200) @(negedge clk);
        check(tx_empty === 1'b0, "R8", "tx_empty while disabled", tx_empty, 0);

        // Asynchronous, factor 16
        k_fac = 16; fac_sel = 2'b01; mon_async = 1'b1; mtag = "R1 R2";
        tx_en = 1'b1;
        repeat (20) @(negedge clk);
        check(tx_empty === 1'b1, "R8", "tx_empty when enabled and idle", tx_empty, 1);
        send(8'hA5);
        check(buf_rdy === 1'b0, "R6", "buf_rdy after write", buf_rdy, 0);
        while (!buf_rdy) @(negedge clk);
        check(tx_empty === 1'b0, "R8", "tx_empty while shifting data", tx_empty, 0);
        send(8'h3C);
        check(buf_rdy === 1'b0, "R7", "holding full before extra write", buf_rdy, 0);
        raw_write(8'hEE);
        check(buf_rdy === 1'b0, "R7", "holding still full after extra write", buf_rdy, 0);
        drain("R7");
        check(tx_empty === 1'b1, "R8", "tx_empty after drain", tx_empty, 1);

        // Asynchronous, factor 1
        k_fac = 1; fac_sel = 2'b00; mtag = "R5";
        send(8'h81);
        send(8'h00);
        drain("R2");

        // Asynchronous, factor 64 (both codes)
        k_fac = 64; fac_sel = 2'b10; mtag = "R2";
        send(8'h5A);
        drain("R2");
        fac_sel = 2'b11;
        send(8'hC3);
        drain("R2");

        // Clear-to-send gate
        k_fac = 16; fac_sel = 2'b01; mtag = "R10";
        cts_n = 1'b1;
        send(8'h69);
        lows = 0;
        repeat (3000) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        check(lows == 0, "R10", "txd low cycles while cts_n high", lows, 0);
        check(buf_rdy === 1'b0, "R10", "character held while cts_n high", buf_rdy, 0);
        cts_n = 1'b0;
        drain("R10");

        // Break
        mon_async = 1'b0;
        brk = 1'b1;
        repeat (5) @(negedge clk);
        lows = 0;
        repeat (1000) begin
            @(negedge clk);
            if (txd !== 1'b0) lows++;
        end
        check(lows == 0, "R9", "txd high cycles during break", lows, 0);
        brk = 1'b0;
        repeat (5) @(negedge clk);
        check(txd === 1'b1, "R9", "txd after break released", txd, 1);

        // Synchronous mode with fill; fac_sel left at the 16 code
        tx_en = 1'b0;
        repeat (300) @(negedge clk);
        sync_mode = 1'b1; fac_sel = 2'b01; k_fac = 1;
        mon_sync = 1'b1;
        tx_en = 1'b1;
        repeat (400) @(negedge clk);
        check(tx_empty === 1'b1, "R8", "tx_empty while only fill is sent", tx_empty, 1);
        check(fills >= 2, "R4", "fill characters before data", fills, 2);
        fills = 0;
        send(8'h42);
        send(8'h99);
        send(8'hF0);
        @(negedge clk);
        while (!tx_empty) @(negedge clk);
        repeat (700) @(negedge clk);
        check(expq.size() == 0, "R3", "characters still expected", expq.size(), 0);
        check(fills >= 3, "R4", "fill characters after data", fills, 3);
        mon_sync = 1'b0;
        repeat (300) @(negedge clk);
        tx_en = 1'b0;
        repeat (300) @(negedge clk);
        check(txd === 1'b1 && tx_empty === 1'b0, "R8", "idle after disable",
              {txd, tx_empty}, 2'b10);

        report();
        $finish;
    end

endmodule